// File: doc/BRIEF.md
# Host-Side Serial Reader for a 10-bit SAR Converter

This block is the host end of a link to a 10-bit successive-approximation converter that answers over a three-wire serial bus. On a start pulse it waits until chip select has been high long enough. It then pulls chip select low and waits out the setup time. After that it drives a run of serial clocks and samples the converter's data line on every rising clock edge, because the converter changes its line on falling edges. When the last clock has finished, it raises chip select and rebuilds the conversion code from the received bits. The code is handed over on a valid/ready output.

A full read is 16 clocks, grouped as two bytes. In the first byte, the first two sampled bits carry no meaning and the third is the null bit. The remaining five bits of that byte are the upper result bits. The second byte carries the lower five result bits, followed by three bits that the converter echoes back in reverse order. The block drops the two meaningless bits and the echo, and it checks the null bit. A short mode stops after 11 clocks and returns only the top eight bits, which shortens each conversion cycle.

The serial clock half-period is a runtime divider input measured in system clocks. A parameter sets its lower bound, so the serial clock can never run faster than the converter allows. Either clock idle level can be chosen. A deadline counter flags a read whose clocks took longer than the time the converter can hold its sampled charge.

Top module: `adcrd_host`

## Requirements
- R1: After reset `cs_n` is 1, `res_valid`, `err_late` and `err_proto` are 0, and `sclk` sits at the `cpol` level.
- R2: A full read (`fast8`=0) gives exactly 16 rising `sclk` edges while `cs_n` is low. Rising edge k samples stream bit k, where bits 1–2 are don't-care, bit 3 is the null bit, bits 4–13 are result bits 9 down to 0, and bits 14–16 are ignored. `res_data` equals result bits 9..0.
- R3: Whenever `cs_n` is high, `sclk` equals `cpol`: 0 means the clock idles low and 1 means it idles high. Both levels sample on rising edges.
- R4: Every high phase and every low phase of `sclk` inside a read lasts H system clocks, where H = max(`div_half`, MIN_HALF). `cs_n` rises 2·H cycles after the last rising edge.
- R5: The first rising `sclk` edge comes exactly SETUP_CYC + H cycles after `cs_n` falls.
- R6: `cs_n` stays high for at least CSH_CYC cycles before it falls again. This also holds for the first read after reset.
- R7: Take D, the number of cycles from the fall of `cs_n` to rising edge 14 (to rising edge 11 in short mode). `err_late` pulses for one cycle as `cs_n` rises exactly when D > LIMIT_CYC. A late result is still delivered.
- R8: A short read (`fast8`=1) gives exactly 11 rising edges. `res_data[9:2]` holds result bits 9..2 and `res_data[1:0]` is 0.
- R9: If the null bit (stream bit 3) is 1, `err_proto` pulses for one cycle as `cs_n` rises, and `res_valid` stays 0.
- R10: Once `res_valid` is 1, it stays 1 and `res_data` stays stable until a cycle with `res_ready` high. The cycle after that handshake, `res_valid` is 0. No read starts while a result is pending.
- R11: A `start` pulse during a read or while a result is pending is ignored. It causes no further fall of `cs_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request for a read; taken only when idle |
| cpol | input | 1 | Serial clock idle level (0 low, 1 high) |
| fast8 | input | 1 | 1 selects the 11-clock, 8-bit short read |
| div_half | input | DIVW | Requested half-period in system clocks, clamped up to MIN_HALF |
| cs_n | output | 1 | Chip select to the converter, active low |
| sclk | output | 1 | Serial clock to the converter |
| miso | input | 1 | Serial data from the converter |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Consumer takes the result |
| res_data | output | 10 | Conversion code |
| err_late | output | 1 | One-cycle pulse: hold-time deadline missed |
| err_proto | output | 1 | One-cycle pulse: null bit was not 0; no result issued |

## Verification
Two functions can coincide in a single cycle. The same edge that ends a read raises chip select, reports the deadline verdict, and either issues the result or reports a protocol error. The bench therefore samples all four outputs in the first cycle after that edge. It compares them with values it derives from the code it sent, the clamped half-period and the mode. Two situations are provoked deliberately: half-periods on both sides of the deadline, and reads whose null bit is forced to 1. A third case is start pulses that arrive while the result is held under back-pressure. It is judged by counting falls of chip select at the pins.

// File: rtl/adcrd_pkg.sv
package adcrd_pkg;
  localparam int FULL_CLKS    = 16;  // clocks in a full two-byte read
  localparam int FAST_CLKS    = 11;  // clocks needed to reach result bit 2
  localparam int DEADLINE_CLK = 14;  // rising edge that must meet the hold limit
  localparam int RES_W        = 10;
  localparam int BIT_CW       = $clog2(FULL_CLKS + 1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_WAIT, ST_SETUP, ST_LOW, ST_HIGH, ST_END, ST_HOLD
  } rd_state_t;
endpackage

// File: rtl/adcrd_unpack.sv
module adcrd_unpack
  import adcrd_pkg::*;
(
  input  logic [FULL_CLKS-1:0] shreg,
  input  logic                 fast,
  output logic [RES_W-1:0]     data,
  output logic                 null_bit
);
  // Stream bit 1 ends up at the top of the shifted window; the null bit is stream bit 3.
  logic unused_lead;
  assign unused_lead = ^shreg[FULL_CLKS-1:FULL_CLKS-2];

  always_comb begin
    if (fast) begin
      null_bit = shreg[FAST_CLKS-3];
      data     = {shreg[FAST_CLKS-4:0], 2'b00};
    end else begin
      null_bit = shreg[FULL_CLKS-3];
      data     = shreg[FULL_CLKS-4:FULL_CLKS-3-RES_W];
    end
  end
endmodule

// File: rtl/adcrd_deadline.sv
module adcrd_deadline #(
  parameter int LIMIT_CYC = 140000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic probe,
  output logic late
);
  localparam int TW = $clog2(LIMIT_CYC + 2);

  logic [TW-1:0] t_q;
  logic          run_q;

  // At the probe edge t_q holds (cycles since arm) - 1.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t_q   <= '0;
      run_q <= 1'b0;
      late  <= 1'b0;
    end else if (arm) begin
      t_q   <= '0;
      run_q <= 1'b1;
      late  <= 1'b0;
    end else begin
      if (run_q && t_q != TW'(LIMIT_CYC)) t_q <= t_q + 1'b1;
      if (probe) begin
        late  <= (t_q >= TW'(LIMIT_CYC));
        run_q <= 1'b0;
      end
    end
  end

  a_r7_late_from_probe: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(late) |-> $past(probe));
endmodule

// File: rtl/adcrd_csgap.sv
module adcrd_csgap #(
  parameter int CSH_CYC = 70
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  output logic gap_ok
);
  localparam int GW = $clog2(CSH_CYC + 1);

  logic [GW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       cnt_q <= '0;
    else if (!cs_n)                   cnt_q <= '0;
    else if (cnt_q != GW'(CSH_CYC))   cnt_q <= cnt_q + 1'b1;
  end

  // A fall decided on this edge leaves cs_n high for cnt_q + 1 cycles.
  assign gap_ok = (cnt_q >= GW'(CSH_CYC - 1));
endmodule

// File: rtl/adcrd_host.sv
module adcrd_host
  import adcrd_pkg::*;
#(
  parameter int DIVW      = 8,
  parameter int MIN_HALF  = 36,
  parameter int SETUP_CYC = 20,
  parameter int CSH_CYC   = 70,
  parameter int LIMIT_CYC = 140000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             cpol,
  input  logic             fast8,
  input  logic [DIVW-1:0]  div_half,
  output logic             cs_n,
  output logic             sclk,
  input  logic             miso,
  output logic             res_valid,
  input  logic             res_ready,
  output logic [RES_W-1:0] res_data,
  output logic             err_late,
  output logic             err_proto
);
  localparam int SW = $clog2(SETUP_CYC + 1);
  localparam int CW = (SW > DIVW) ? SW : DIVW;

  rd_state_t            st_q;
  logic [CW-1:0]        cnt_q, half_q;
  logic [BIT_CW-1:0]    bits_q;
  logic [FULL_CLKS-1:0] sh_q;
  logic                 fast_q, mode_q;
  logic                 cs_q, sclk_q, vld_q, late_q, proto_q;
  logic [RES_W-1:0]     data_q;

  logic [DIVW-1:0]      half_eff;
  logic [BIT_CW-1:0]    bits_nxt, n_clks, dl_clk;
  logic                 phase_end, gap_ok, arm, probe, dl_late;
  logic [RES_W-1:0]     unpk_data;
  logic                 null_bit;

  assign half_eff  = (div_half < DIVW'(MIN_HALF)) ? DIVW'(MIN_HALF) : div_half;
  assign phase_end = (cnt_q == half_q - CW'(1));
  assign bits_nxt  = bits_q + 1'b1;
  assign n_clks    = fast_q ? BIT_CW'(FAST_CLKS) : BIT_CW'(FULL_CLKS);
  assign dl_clk    = fast_q ? BIT_CW'(FAST_CLKS) : BIT_CW'(DEADLINE_CLK);
  assign arm       = (st_q == ST_WAIT) && gap_ok;
  assign probe     = (st_q == ST_LOW) && phase_end && (bits_nxt == dl_clk);

  adcrd_csgap #(.CSH_CYC(CSH_CYC)) u_gap (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_q), .gap_ok(gap_ok));

  adcrd_deadline #(.LIMIT_CYC(LIMIT_CYC)) u_dl (
    .clk(clk), .rst_n(rst_n), .arm(arm), .probe(probe), .late(dl_late));

  adcrd_unpack u_unpk (
    .shreg(sh_q), .fast(fast_q), .data(unpk_data), .null_bit(null_bit));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      half_q  <= '0;
      bits_q  <= '0;
      sh_q    <= '0;
      fast_q  <= 1'b0;
      mode_q  <= 1'b0;
      cs_q    <= 1'b1;
      sclk_q  <= 1'b0;
      vld_q   <= 1'b0;
      data_q  <= '0;
      late_q  <= 1'b0;
      proto_q <= 1'b0;
    end else begin
      late_q  <= 1'b0;
      proto_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          sclk_q <= cpol;
          if (start) begin
            mode_q <= cpol;
            fast_q <= fast8;
            half_q <= CW'(half_eff);
            st_q   <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          sclk_q <= mode_q;
          if (gap_ok) begin
            cs_q   <= 1'b0;
            cnt_q  <= '0;
            bits_q <= '0;
            sh_q   <= '0;
            st_q   <= ST_SETUP;
          end
        end
        ST_SETUP: begin
          if (cnt_q == CW'(SETUP_CYC - 1)) begin
            cnt_q  <= '0;
            sclk_q <= 1'b0;
            st_q   <= ST_LOW;
          end else cnt_q <= cnt_q + 1'b1;
        end
        ST_LOW: begin
          if (phase_end) begin
            cnt_q  <= '0;
            sclk_q <= 1'b1;
            sh_q   <= {sh_q[FULL_CLKS-2:0], miso};
            bits_q <= bits_nxt;
            st_q   <= ST_HIGH;
          end else cnt_q <= cnt_q + 1'b1;
        end
        ST_HIGH: begin
          if (phase_end) begin
            cnt_q <= '0;
            if (bits_q == n_clks) begin
              sclk_q <= mode_q;
              st_q   <= ST_END;
            end else begin
              sclk_q <= 1'b0;
              st_q   <= ST_LOW;
            end
          end else cnt_q <= cnt_q + 1'b1;
        end
        ST_END: begin
          if (phase_end) begin
            cnt_q  <= '0;
            cs_q   <= 1'b1;
            late_q <= dl_late;
            if (null_bit) begin
              proto_q <= 1'b1;
              st_q    <= ST_IDLE;
            end else begin
              vld_q  <= 1'b1;
              data_q <= unpk_data;
              st_q   <= ST_HOLD;
            end
          end else cnt_q <= cnt_q + 1'b1;
        end
        ST_HOLD: begin
          sclk_q <= cpol;
          if (res_ready) begin
            vld_q <= 1'b0;
            st_q  <= ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign cs_n      = cs_q;
  assign sclk      = sclk_q;
  assign res_valid = vld_q;
  assign res_data  = data_q;
  assign err_late  = late_q;
  assign err_proto = proto_q;

  a_r10_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_data));

  a_r9_no_valid_on_proto: assert property (@(posedge clk) disable iff (!rst_n)
    err_proto |-> !res_valid);

  a_r6_gap_before_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> $past(gap_ok));

  a_r3_idle_level_on_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> sclk == mode_q);

  a_r2_bit_bound: assert property (@(posedge clk) disable iff (!rst_n)
    bits_q <= BIT_CW'(FULL_CLKS));

  a_r11_one_frame_at_a_time: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> !res_valid);
endmodule

// File: tb/adcrd_host_tb.sv
`timescale 1ns/100ps
module adcrd_host_tb;
  localparam int MIN_HALF  = 36;
  localparam int SETUP_CYC = 20;
  localparam int CSH_CYC   = 70;
  localparam int LIMIT_CYC = 1500;
  localparam int WD_LIMIT  = 190000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0, cpol = 1'b0, fast8 = 1'b0, miso = 1'b0, res_ready = 1'b0;
  logic [7:0] div_half = 8'd0;
  logic       cs_n, sclk, res_valid, err_late, err_proto;
  logic [9:0] res_data;

  always #2.5 clk = ~clk;

  adcrd_host #(.DIVW(8), .MIN_HALF(MIN_HALF), .SETUP_CYC(SETUP_CYC),
               .CSH_CYC(CSH_CYC), .LIMIT_CYC(LIMIT_CYC)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .cpol(cpol), .fast8(fast8),
    .div_half(div_half), .cs_n(cs_n), .sclk(sclk), .miso(miso),
    .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data),
    .err_late(err_late), .err_proto(err_proto));

  int n_chk = 0, n_bad = 0;
  int cyc = 0;

  // converter model and pin monitor state
  logic [9:0] cur_code = '0;
  bit   inj_null = 1'b0;
  int   cur_h = MIN_HALF;
  int   t_csfall = 0, t_csrise = 0, t_lastrise = 0, t_lastedge = 0, first_rise = 0;
  int   rises = 0, nedges = 0, width_bad = 0, idle_bad = 0, falls = 0, gap = 0, end_gap = 0;
  logic prev_cs = 1'b1, prev_sclk = 1'b0;

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == WD_LIMIT) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      summary();
      $finish;
    end
  end

  // stream bit emitted after the fall that follows rising edge n
  function automatic logic stream_bit(input int n);
    if (n == 1)       return logic'($urandom % 2);
    if (n == 2)       return inj_null;
    if (n <= 12)      return cur_code[12-n];
    if (n == 13)      return cur_code[1];
    if (n == 14)      return cur_code[2];
    if (n == 15)      return cur_code[3];
    return 1'b0;
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_cs && !cs_n) begin
        t_csfall = cyc; rises = 0; nedges = 0; gap = cyc - t_csrise; falls++;
        miso = logic'($urandom % 2);
      end
      if (!prev_cs && cs_n) begin
        t_csrise = cyc; end_gap = cyc - t_lastrise;
        miso = logic'($urandom % 2);
      end
      if (!cs_n && sclk != prev_sclk) begin
        nedges++;
        if (nedges > 1 && cyc - t_lastedge != cur_h) width_bad++;
        t_lastedge = cyc;
        if (sclk) begin
          rises++;
          if (rises == 1) first_rise = cyc;
          t_lastrise = cyc;
        end else if (rises >= 1) begin
          miso = stream_bit(rises);
        end
      end
      if (cs_n && prev_cs && sclk != cpol) idle_bad++;
    end
    prev_cs = cs_n;
    prev_sclk = sclk;
  end

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [9:0] exp_data(input logic [9:0] code, input bit fast);
    return fast ? {code[9:2], 2'b00} : code;
  endfunction

  function automatic bit exp_late(input int h, input bit fast);
    int edge_n = fast ? 11 : 14;
    int d = SETUP_CYC + h + (edge_n - 1) * 2 * h;
    return d > LIMIT_CYC;
  endfunction

  task automatic run_frame(input logic [9:0] code, input bit fast, input bit mode,
                           input int div, input bit inj, input int hold, input bit poke);
    int w; int h; int n; int f0; int ib0; int sbad;
    logic [9:0] held;
    h = (div < MIN_HALF) ? MIN_HALF : div;
    n = fast ? 11 : 16;
    cur_code = code; inj_null = inj; cur_h = h;
    cpol = mode; fast8 = fast; div_half = 8'(div);
    step(); step();
    f0 = falls; ib0 = idle_bad; width_bad = 0;
    start = 1'b1; step(); start = 1'b0;
    w = 0;
    while (!res_valid && !err_proto && w < 20000) begin
      start = (poke && w == 100);
      step(); w++;
    end
    start = 1'b0;
    chk(w < 20000, "R2", "read completes", w, 0);
    chk(err_proto == inj, "R9", "protocol error pulse", int'(err_proto), int'(inj));
    chk(res_valid == !inj, "R9", "valid only with good null bit", int'(res_valid), int'(!inj));
    if (!inj)
      chk(res_data == exp_data(code, fast), fast ? "R8" : "R2", "result code",
          int'(res_data), int'(exp_data(code, fast)));
    chk(err_late == exp_late(h, fast), "R7", "deadline flag", int'(err_late), int'(exp_late(h, fast)));
    chk(rises == n, fast ? "R8" : "R2", "rising edges", rises, n);
    chk(first_rise - t_csfall == SETUP_CYC + h, "R5", "select to first edge",
        first_rise - t_csfall, SETUP_CYC + h);
    chk(width_bad == 0, "R4", "phase width errors", width_bad, 0);
    chk(end_gap == 2 * h, "R4", "last edge to release", end_gap, 2 * h);
    chk(idle_bad == ib0, "R3", "idle level errors", idle_bad - ib0, 0);
    chk(gap >= CSH_CYC, "R6", "select high time", gap, CSH_CYC);
    chk(falls == f0 + 1, "R11", "select falls per read", falls - f0, 1);
    if (!inj) begin
      held = res_data; sbad = 0;
      for (int i = 0; i < hold; i++) begin
        start = (i % 2 == 0);
        step();
        if (!res_valid || res_data != held) sbad++;
      end
      start = 1'b0;
      chk(sbad == 0, "R10", "result held under back-pressure", sbad, 0);
      chk(falls == f0 + 1, "R10", "no read while result pending", falls - f0, 1);
      res_ready = 1'b1; step(); res_ready = 1'b0;
      chk(!res_valid, "R10", "valid after handshake", int'(res_valid), 0);
    end
    if (poke) begin
      repeat (300) step();
      chk(falls == f0 + 1 && cs_n, "R11", "start during read ignored", falls - f0, 1);
    end
    step();
  endtask

  initial begin
    void'($urandom(32'd4021));
    repeat (5) step();
    rst_n = 1'b1;
    step(); step();
    // R1 reset state
    chk(cs_n == 1'b1, "R1", "cs_n after reset", int'(cs_n), 1);
    chk(!res_valid && !err_late && !err_proto, "R1", "outputs after reset",
        int'({res_valid, err_late, err_proto}), 0);
    chk(sclk == cpol, "R1", "sclk after reset", int'(sclk), int'(cpol));

    run_frame(10'h3FF, 1'b0, 1'b0, 36, 1'b0, 3, 1'b0);
    run_frame(10'h000, 1'b0, 1'b1, 5,  1'b0, 0, 1'b0);   // R4 divider clamp
    run_frame(10'h2AA, 1'b1, 1'b1, 40, 1'b0, 2, 1'b0);   // R8 short read
    run_frame(10'h155, 1'b0, 1'b0, 54, 1'b0, 1, 1'b0);   // R7 just inside limit
    run_frame(10'h155, 1'b0, 1'b1, 55, 1'b0, 1, 1'b0);   // R7 just past limit
    run_frame(10'h1C3, 1'b1, 1'b0, 70, 1'b0, 0, 1'b0);   // R7 short, inside
    run_frame(10'h0F0, 1'b1, 1'b1, 71, 1'b0, 0, 1'b0);   // R7 short, past
    run_frame(10'h222, 1'b0, 1'b0, 40, 1'b1, 0, 1'b0);   // R9 bad null bit
    run_frame(10'h301, 1'b0, 1'b1, 38, 1'b0, 8, 1'b1);   // R10 and R11 pokes
    for (int k = 0; k < 24; k++) begin
      run_frame(10'($urandom % 1024), ($urandom % 4) == 0, 1'($urandom % 2),
                int'($urandom % 71), ($urandom % 8) == 0, int'($urandom % 6), 1'b0);
    end
    summary();
    $finish;
  end
endmodule